// File: doc/BRIEF.md
# Downlink Transfer Frame Assembler

The block turns a stream of instrument payload units into fixed-length downlink frames, one octet per cycle. Each unit arrives as an octet stream whose first octet carries a start marker and whose last carries an end marker. Around the unit the block places a 32-bit sync word, a 6-octet primary header, a 16-bit CRC trailer and a 256-octet parity field, for a frame of 2044 octets. The parity octets are either taken from a side input or forced to zero; the block does no Reed-Solomon coding. The spacecraft ID is a configuration input. The virtual channel ID is sampled with the start octet of each unit, and a separate 24-bit frame counter is kept for each channel.

The payload is not buffered. Octets flow from the input to the output, so upstream sees the downstream backpressure. A unit that is too short is padded with zero octets, and a unit that is too long is cut at 1776 octets with the surplus dropped. Either case flags an error on the last octet of the frame, and the channel counter still advances.

The controller is one state machine:
- IDLE waits for a start octet and drops stray octets. It goes to SYNC on start.
- SYNC sends the four sync octets. It goes to HDR.
- HDR sends the header. It goes to PAY.
- PAY passes or pads the payload. It goes to CRC after octet 1776.
- CRC sends the two check octets. It goes to PAR.
- PAR sends the parity field. It goes to IDLE, or to DROP if the unit overran.
- DROP discards input up to the end marker. It goes to IDLE.

Top module: `tm_frame_asm`

## Requirements
- R1: The first four octets of every frame are 0x1A, 0xCF, 0xFC, 0x1D, and `out_sof` is high on the first of them only.
- R2: Octets 5 to 10 are the 48-bit header, most significant bit first: `01`, spacecraft ID (8), channel ID (6), frame counter (24), replay flag `0`, then seven `0` bits.
- R3: A unit of exactly 1776 octets appears unchanged and in order as frame octets 11 to 1786.
- R4: The next two octets are a CRC, high octet first. It uses polynomial 0x1021, starts at 0xFFFF, has no final inversion, and covers the header and payload octets as sent.
- R5: The last 256 octets are parity. With `cfg_par_en`=1 each one equals `par_data`, and `par_take` pulses once per octet sent. With `cfg_par_en`=0 they are 0x00 and `par_take` stays low.
- R6: Every frame is exactly 2044 octets, and `out_eof` is high on the last one only.
- R7: Each of the 64 channels has its own counter. It is 0 after reset, goes into the header of that channel's next frame, and then increases by one.
- R8: A unit that ends before 1776 octets is padded with 0x00 to full length, and `out_err` is high with `out_eof`.
- R9: A unit longer than 1776 octets is cut to 1776. Its extra octets up to the end marker are dropped, `out_err` is high with `out_eof`, and the next unit is framed normally.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R11: Input octets that arrive outside a unit are accepted and dropped, and produce no output.
- R12: After reset `out_valid` is low. `out_err` stays low on frames built from 1776-octet units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_scid | input | 8 | Spacecraft ID placed in every header |
| cfg_par_en | input | 1 | 1: parity octets come from par_data; 0: zeros |
| in_valid | input | 1 | Input octet valid |
| in_ready | output | 1 | Input octet accepted when high with in_valid |
| in_data | input | 8 | Input payload octet |
| in_sof | input | 1 | Marks the first octet of a unit |
| in_eof | input | 1 | Marks the last octet of a unit |
| in_vcid | input | 6 | Virtual channel ID, sampled with the start octet |
| par_data | input | 8 | Parity octet from the side source |
| par_take | output | 1 | Current par_data octet is consumed this cycle |
| out_valid | output | 1 | Output octet valid |
| out_ready | input | 1 | Downstream accepts the output octet |
| out_data | output | 8 | Output frame octet |
| out_sof | output | 1 | First octet of a frame |
| out_eof | output | 1 | Last octet of a frame |
| out_err | output | 1 | Frame came from a unit of wrong length; valid with out_eof |

## Verification
The patterns are:
- Well-formed 1776-octet units on a repeated channel and on fresh channels. These separate correct per-channel counting from a single shared counter.
- The same units under random output backpressure and with parity on. These show whether pass-through, stall holding and the parity handshake stay aligned.
- A short unit, a one-octet unit that carries start and end together, and a 1780-octet unit. These exercise padding, truncation, the error flag and recovery.
- Stray octets sent before a unit. These show that octets outside a unit are dropped and not framed.

Every frame octet is compared with a model frame that includes an independently computed CRC. A wrong octet position, a wrong CRC or a lost handshake therefore each show up as a mismatch.

// File: rtl/tm_frame_pkg.sv
package tm_frame_pkg;

    localparam logic [31:0] SYNC_WORD  = 32'h1ACF_FC1D;
    localparam logic [1:0]  TF_VERSION = 2'b01;
    localparam int          SYNC_LEN   = 4;
    localparam int          CRC_LEN    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_HDR,
        ST_PAY,
        ST_CRC,
        ST_PAR,
        ST_DROP
    } asm_state_t;

    // One octet step of the CCITT CRC, shifted MSB first.
    function automatic logic [15:0] crc_step(input logic [15:0] acc, input logic [7:0] octet);
        logic [15:0] c;
        logic        fb;
        c = acc;
        for (int b = 7; b >= 0; b--) begin
            fb = c[15] ^ octet[b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

endpackage

// File: rtl/tm_crc16.sv
module tm_crc16
    import tm_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    logic [15:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc_q <= 16'hFFFF;
        else if (init) acc_q <= 16'hFFFF;
        else if (en)   acc_q <= crc_step(acc_q, din);
    end

    assign crc = acc_q;

endmodule

// File: rtl/tm_vc_counters.sv
module tm_vc_counters #(
    parameter int VC_W  = 6,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VC_W-1:0]  sel,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam int NUM_VC = 1 << VC_W;

    logic [NUM_VC*CNT_W-1:0] flat;

    for (genvar g = 0; g < NUM_VC; g++) begin : g_chan
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (bump && (sel == VC_W'(g)))
                cnt_q <= cnt_q + 1'b1;
        end
        assign flat[g*CNT_W +: CNT_W] = cnt_q;
    end

    assign count = flat[sel*CNT_W +: CNT_W];

endmodule

// File: rtl/tm_hdr_mux.sv
module tm_hdr_mux
    import tm_frame_pkg::*;
#(
    parameter int SCID_W = 8,
    parameter int VC_W   = 6,
    parameter int CNT_W  = 24,
    parameter int POS_W  = 4
) (
    input  logic [POS_W-1:0] pos,
    input  logic [SCID_W-1:0] scid,
    input  logic [VC_W-1:0]  vcid,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       octet
);

    localparam int HDR_BITS = 2 + SCID_W + VC_W + CNT_W + 8;
    localparam int TOT_LEN  = SYNC_LEN + HDR_BITS / 8;

    logic [TOT_LEN*8-1:0] lead;

    assign lead = {SYNC_WORD, TF_VERSION, scid, vcid, cnt, 1'b0, 7'b0};

    always_comb begin
        octet = 8'h00;
        for (int k = 0; k < TOT_LEN; k++) begin
            if (pos == POS_W'(k)) octet = lead[(TOT_LEN-1-k)*8 +: 8];
        end
    end

endmodule

// File: rtl/tm_frame_asm.sv
module tm_frame_asm
    import tm_frame_pkg::*;
#(
    parameter int PAY_LEN = 1776,
    parameter int PAR_LEN = 256,
    parameter int SCID_W  = 8,
    parameter int VC_W    = 6,
    parameter int CNT_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SCID_W-1:0] cfg_scid,
    input  logic              cfg_par_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [VC_W-1:0]   in_vcid,
    input  logic [7:0]        par_data,
    output logic              par_take,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err
);

    localparam int HDR_LEN   = (2 + SCID_W + VC_W + CNT_W + 8) / 8;
    localparam int FRAME_LEN = SYNC_LEN + HDR_LEN + PAY_LEN + CRC_LEN + PAR_LEN;
    localparam int MAX_SEG   = (PAY_LEN > PAR_LEN) ? PAY_LEN : PAR_LEN;
    localparam int IDX_W     = $clog2(MAX_SEG);
    localparam int POS_W     = $clog2(SYNC_LEN + HDR_LEN);
    localparam int LEN_W     = $clog2(FRAME_LEN + 1);

    localparam logic [IDX_W-1:0] SYNC_LAST = IDX_W'(SYNC_LEN - 1);
    localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] PAY_LAST  = IDX_W'(PAY_LEN - 1);
    localparam logic [IDX_W-1:0] CRC_LAST  = IDX_W'(CRC_LEN - 1);
    localparam logic [IDX_W-1:0] PAR_LAST  = IDX_W'(PAR_LEN - 1);

    asm_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              ended_q, ended_d;
    logic              over_q, over_d;
    logic              err_q, err_d;
    logic [VC_W-1:0]   vcid_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              start;
    logic              xfer;
    logic [CNT_W-1:0]  cnt_rd;
    logic [15:0]       crc;
    logic [7:0]        lead_octet;
    logic [POS_W-1:0]  lead_pos;
    logic              crc_en;

    assign xfer = out_valid && out_ready;

    tm_vc_counters #(.VC_W(VC_W), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (in_vcid),
        .bump  (start),
        .count (cnt_rd)
    );

    assign lead_pos = (state_q == ST_SYNC) ? POS_W'(idx_q)
                                           : POS_W'(SYNC_LEN + int'(idx_q));

    tm_hdr_mux #(.SCID_W(SCID_W), .VC_W(VC_W), .CNT_W(CNT_W), .POS_W(POS_W)) u_hdr (
        .pos   (lead_pos),
        .scid  (cfg_scid),
        .vcid  (vcid_q),
        .cnt   (cnt_q),
        .octet (lead_octet)
    );

    assign crc_en = xfer && ((state_q == ST_HDR) || (state_q == ST_PAY));

    tm_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start),
        .en    (crc_en),
        .din   (out_data),
        .crc   (crc)
    );

    // Next-state and sequencing decisions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        ended_d = ended_q;
        over_d  = over_q;
        err_d   = err_q;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    start   = 1'b1;
                    state_d = ST_SYNC;
                    idx_d   = '0;
                    ended_d = 1'b0;
                    over_d  = 1'b0;
                    err_d   = 1'b0;
                end
            end
            ST_SYNC: begin
                if (xfer) begin
                    if (idx_q == SYNC_LAST) begin
                        state_d = ST_HDR;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (xfer) begin
                    if (idx_q == HDR_LAST) begin
                        state_d = ST_PAY;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (xfer) begin
                    if (idx_q == PAY_LAST) begin
                        state_d = ST_CRC;
                        idx_d   = '0;
                        if (!ended_q && !in_eof) begin
                            over_d = 1'b1;
                            err_d  = 1'b1;
                        end
                    end else begin
                        idx_d = idx_q + 1'b1;
                        if (!ended_q && in_eof) begin
                            ended_d = 1'b1;
                            err_d   = 1'b1;
                        end
                    end
                end
            end
            ST_CRC: begin
                if (xfer) begin
                    if (idx_q == CRC_LAST) begin
                        state_d = ST_PAR;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (xfer) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == PAR_LAST) begin
                        idx_d   = '0;
                        state_d = over_q ? ST_DROP : ST_IDLE;
                    end
                end
            end
            ST_DROP: begin
                if (in_valid && in_eof) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ended_q <= 1'b0;
            over_q  <= 1'b0;
            err_q   <= 1'b0;
            vcid_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            ended_q <= ended_d;
            over_q  <= over_d;
            err_q   <= err_d;
            if (start) begin
                vcid_q <= in_vcid;
                cnt_q  <= cnt_rd;
            end
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        out_err   = 1'b0;
        in_ready  = 1'b0;
        par_take  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = !in_sof;
            end
            ST_SYNC: begin
                out_valid = 1'b1;
                out_data  = lead_octet;
                out_sof   = (idx_q == '0);
            end
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = lead_octet;
            end
            ST_PAY: begin
                if (ended_q) begin
                    out_valid = 1'b1;
                    out_data  = 8'h00;
                end else begin
                    out_valid = in_valid;
                    out_data  = in_data;
                    in_ready  = out_ready;
                end
            end
            ST_CRC: begin
                out_valid = 1'b1;
                out_data  = (idx_q == '0) ? crc[15:8] : crc[7:0];
            end
            ST_PAR: begin
                out_valid = 1'b1;
                out_data  = cfg_par_en ? par_data : 8'h00;
                par_take  = cfg_par_en && out_ready;
                out_eof   = (idx_q == PAR_LAST);
                out_err   = (idx_q == PAR_LAST) && err_q;
            end
            ST_DROP: begin
                in_ready = 1'b1;
            end
            default: ;
        endcase
    end

    // Octets sent since the last start-of-frame, for the length check
    logic [LEN_W-1:0] sent_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             sent_q <= '0;
        else if (xfer && out_sof) sent_q <= LEN_W'(1);
        else if (xfer)          sent_q <= sent_q + 1'b1;
    end

    AST_SOF_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_data == SYNC_WORD[31:24])); // R1

    AST_PAR_FROM_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        par_take |-> (out_valid && out_data == par_data)); // R5

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && out_eof) |-> (sent_q == LEN_W'(FRAME_LEN - 1))); // R6

    AST_ERR_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_eof); // R8

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

endmodule

// File: tb/tm_frame_asm_tb_top.sv
module tm_frame_asm_tb_top;

    localparam int PAY = 1776;
    localparam int PAR = 256;

    typedef struct {
        logic [7:0] d;
        bit         s;
        bit         e;
        bit         er;
        string      tag;
        string      etag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_scid = 8'hA5;
    logic       cfg_par_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic [5:0] in_vcid = '0;
    logic [7:0] par_data;
    logic       par_take;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_sof;
    logic       out_eof;
    logic       out_err;

    tm_frame_asm dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_scid(cfg_scid), .cfg_par_en(cfg_par_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_vcid(in_vcid),
        .par_data(par_data), .par_take(par_take),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
    );

    always #2 clk = ~clk;

    int         n_checks = 0;
    int         n_fail   = 0;
    bit         bp_on    = 1'b0;
    bit         done     = 1'b0;
    exp_t       exp_q[$];
    logic [23:0] exp_cnt [64];
    int         pexp   = 0;
    int         pcount = 0;
    bit         take_pend = 1'b0;
    bit         hold_pend = 1'b0;
    logic [7:0] hold_d;

    assign par_data = 8'(pcount) ^ 8'h5A;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        m;
        r = c;
        for (int i = 0; i < 8; i++) begin
            m = r[15] ^ b[7-i];
            r = r << 1;
            if (m) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    // Stimulus side effects: backpressure and side parity source
    always @(posedge clk) begin
        #1;
        if (take_pend) pcount++;
        out_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend)
                chk(out_valid && out_data == hold_d, "R10 hold", {out_valid, out_data}, {1'b1, hold_d});
            hold_pend = out_valid && !out_ready;
            hold_d    = out_data;
            take_pend = par_take;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected output", out_data, 0);
                end else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    chk(out_data == x.d && out_sof == x.s, x.tag, {out_sof, out_data}, {x.s, x.d});
                    chk(out_eof == x.e && out_err == x.er, x.etag, {out_eof, out_err}, {x.e, x.er});
                end
            end
        end
    end

    task automatic push(input logic [7:0] d, input bit s, input bit e, input bit er,
                        input string tag, input string etag);
        exp_t x;
        x.d = d; x.s = s; x.e = e; x.er = er; x.tag = tag; x.etag = etag;
        exp_q.push_back(x);
    endtask

    task automatic drive_byte(input logic [7:0] d, input bit s, input bit e, input logic [5:0] vc);
        in_data = d; in_sof = s; in_eof = e; in_vcid = vc; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
    endtask

    task automatic send_unit(input logic [5:0] vc, input int len, input logic [7:0] seed);
        logic [47:0] h;
        logic [15:0] c;
        logic [7:0]  b;
        string       ptag;
        string       etag;
        h = {2'b01, cfg_scid, vc, exp_cnt[vc], 1'b0, 7'b0};
        c = 16'hFFFF;
        ptag = (len < PAY) ? "R8 payload/pad" : (len > PAY) ? "R9 truncated payload" : "R3 payload";
        etag = (len < PAY) ? "R8 err flag" : (len > PAY) ? "R9 err flag" : "R12 no err";
        push(8'h1A, 1, 0, 0, "R1 sync", "R6 eof");
        push(8'hCF, 0, 0, 0, "R1 sync", "R6 eof");
        push(8'hFC, 0, 0, 0, "R1 sync", "R6 eof");
        push(8'h1D, 0, 0, 0, "R1 sync", "R6 eof");
        for (int i = 0; i < 6; i++) begin
            b = h[47-8*i -: 8];
            c = ref_crc(c, b);
            push(b, 0, 0, 0, (i >= 2 && i <= 4) ? "R7 counter" : "R2 header", "R6 eof");
        end
        for (int i = 0; i < PAY; i++) begin
            b = (i < len) ? 8'(int'(seed) + 3 * i) : 8'h00;
            c = ref_crc(c, b);
            push(b, 0, 0, 0, ptag, "R6 eof");
        end
        push(c[15:8], 0, 0, 0, "R4 crc", "R6 eof");
        push(c[7:0], 0, 0, 0, "R4 crc", "R6 eof");
        for (int i = 0; i < PAR; i++) begin
            b = cfg_par_en ? (8'(pexp) ^ 8'h5A) : 8'h00;
            if (cfg_par_en) pexp++;
            push(b, 0, i == PAR - 1, (i == PAR - 1) && (len != PAY), "R5 parity",
                 (i == PAR - 1) ? etag : "R6 eof");
        end
        exp_cnt[vc] = exp_cnt[vc] + 1'b1;
        for (int i = 0; i < len; i++)
            drive_byte(8'(int'(seed) + 3 * i), i == 0, i == len - 1, vc);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R6 watchdog expired", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        for (int v = 0; v < 64; v++) exp_cnt[v] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R12 reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R11 idle accepts input", in_ready, 1);
        @(posedge clk); #1;

        send_unit(6'd3, PAY, 8'h10);                  // R3, R7 counter 0
        wait_idle();
        cfg_par_en = 1'b1; bp_on = 1'b1;
        send_unit(6'd3, PAY, 8'h77);                  // R5, R10, R7 counter 1
        wait_idle();
        cfg_par_en = 1'b0;
        send_unit(6'd10, PAY, 8'h02);                 // R7 fresh channel
        wait_idle();
        send_unit(6'd3, 100, 8'h40);                  // R8 short unit, counter 2
        wait_idle();
        bp_on = 1'b0;
        send_unit(6'd5, PAY + 4, 8'h99);              // R9 long unit
        wait_idle();
        for (int i = 0; i < 5; i++) drive_byte(8'hE0 + 8'(i), 1'b0, i == 4, 6'd3);  // R11
        in_valid = 1'b0; in_eof = 1'b0;
        repeat (4) @(posedge clk); #1;
        chk(exp_q.size() == 0, "R11 stray octets dropped", exp_q.size(), 0);
        send_unit(6'd3, PAY, 8'h21);                  // R11 normal after stray, counter 3
        wait_idle();
        cfg_scid = 8'h3C;
        send_unit(6'd63, 1, 8'hC3);                   // R8 single-octet unit
        wait_idle();
        cfg_par_en = 1'b1; bp_on = 1'b1;
        send_unit(6'd5, PAY, 8'h55);                  // R9 recovery, R7 counter 1
        wait_idle();
        bp_on = 1'b0;
        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R6 all frames complete", exp_q.size(), 0);
        finish_run();
    end

endmodule